// File: doc/BRIEF.md
# Conditional Halfword/Word DSP ALU

This block is the arithmetic and logic stage of a fixed-point DSP datapath. Each clock it takes two operands, an operation code, a condition mode, the current condition flag and the present contents of the destination register. On the next edge it registers either the computed result or the unchanged destination value. It offers five operations: a full-width wrapping add, an add that uses the condition flag as carry-in, and three upper-halfword operations (AND, increment, decrement) that clear the lower halfword.

Writeback can be unconditional, or gated by the flag: it happens only when the flag is set, or only when it is clear. A write that is suppressed passes the supplied destination value through, so the destination register is left as it was. The block also registers the condition flag. A written add-with-carry replaces the flag with its carry-out. Every other cycle passes the incoming flag through unchanged. Nothing else is touched.

Top module: `cdalu_top`

## Requirements
- R1: While `rst_n` is low, `dst_q` is 0 and `flag_q` is 0.
- R2: Operation code 0 (add) writes `(src_a + src_b) mod 2^32`.
- R3: Operation code 1 (add with carry) writes `(src_a + src_b + flag_in) mod 2^32`. When written, `flag_q` becomes the carry out of bit 31.
- R4: Operation code 2 (AND) writes `src_a[31:16] & src_b[31:16]` into bits 31:16 and 0 into bits 15:0.
- R5: Operation code 3 (increment) writes `(src_a[31:16] + 1) mod 2^16` into bits 31:16 and 0 into bits 15:0.
- R6: Operation code 4 (decrement) writes `(src_a[31:16] - 1) mod 2^16` into bits 31:16 and 0 into bits 15:0.
- R7: Condition mode 0 always writes. Mode 1 writes only when `flag_in` is 1. Mode 2 writes only when `flag_in` is 0. Mode 3 never writes. A cycle with no write loads `dst_cur` into `dst_q` unchanged.
- R8: Operation codes 5, 6 and 7 never write: `dst_q` takes `dst_cur`.
- R9: In every cycle other than a written add-with-carry, `flag_q` takes `flag_in`.
- R10: Results appear on `dst_q` and `flag_q` one clock edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 32 | First operand; the only source for increment and decrement |
| src_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 add-carry, 2 AND, 3 inc, 4 dec) |
| cond_mode | input | 2 | Writeback condition (0 always, 1 if set, 2 if clear, 3 never) |
| flag_in | input | 1 | Current condition flag; carry-in for add-with-carry |
| dst_cur | input | 32 | Present destination value, kept when no write occurs |
| dst_q | output | 32 | Registered destination |
| flag_q | output | 1 | Registered condition flag |

## Verification
The bench sweeps every operation code, every condition mode and both flag values over operand patterns chosen to break things. A design that gates on the wrong flag polarity would overwrite the destination in the wrong mode. One that leaves the low half live in the halfword operations would show the low bits of an AND or a carried sum. Separate cases cover the halfword wrap: increment of 0xFFFF and decrement of 0x0000 must not borrow into or leak from the low half. Add-with-carry with all ones plus the flag must wrap to zero and raise the flag. A design that updates the flag on a suppressed or non-carry operation shows a flag that differs from the incoming one.

// File: rtl/cdalu_pkg.sv
package cdalu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDC = 3'd1,
      OP_AND  = 3'd2,
      OP_INC  = 3'd3,
      OP_DEC  = 3'd4
   } cdalu_op_e;

   typedef enum logic [1:0] {
      CM_ALWAYS = 2'd0,
      CM_IFSET  = 2'd1,
      CM_IFCLR  = 2'd2,
      CM_NEVER  = 2'd3
   } cdalu_cmode_e;

   function automatic logic op_known(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

endpackage

// File: rtl/cdalu_arith.sv
module cdalu_arith
   import cdalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [2:0]        op,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W:0] wide_sum;
   logic [HALF_W-1:0] hi_up, hi_dn;
   logic use_cin;

   assign use_cin  = (op == OP_ADDC) & cin;
   assign wide_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, use_cin};
   assign hi_up    = a[DATA_W-1:HALF_W] + HALF_W'(1);
   assign hi_dn    = a[DATA_W-1:HALF_W] - HALF_W'(1);

   always_comb begin
      res  = '0;
      cout = 1'b0;
      case (op)
         OP_ADD, OP_ADDC: begin
            res  = wide_sum[DATA_W-1:0];
            cout = wide_sum[DATA_W];
         end
         OP_INC:  res = {hi_up, {HALF_W{1'b0}}};
         OP_DEC:  res = {hi_dn, {HALF_W{1'b0}}};
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/cdalu_logic.sv
module cdalu_logic #(
   parameter int HALF_W = 16
) (
   input  logic [HALF_W-1:0] a_hi,
   input  logic [HALF_W-1:0] b_hi,
   output logic [2*HALF_W-1:0] res
);
   assign res = {a_hi & b_hi, {HALF_W{1'b0}}};
endmodule

// File: rtl/cdalu_cond.sv
module cdalu_cond
   import cdalu_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       flag,
   input  logic [2:0] op,
   output logic       wr_en
);
   logic cond_ok;

   always_comb begin
      case (mode)
         CM_ALWAYS: cond_ok = 1'b1;
         CM_IFSET:  cond_ok = flag;
         CM_IFCLR:  cond_ok = ~flag;
         default:   cond_ok = 1'b0;
      endcase
   end

   assign wr_en = cond_ok & op_known(op);
endmodule

// File: rtl/cdalu_top.sv
module cdalu_top
   import cdalu_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter bit FLAG_FROM_CARRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [2:0]        op_sel,
   input  logic [1:0]        cond_mode,
   input  logic              flag_in,
   input  logic [DATA_W-1:0] dst_cur,
   output logic [DATA_W-1:0] dst_q,
   output logic              flag_q
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("cdalu_top: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] arith_res, logic_res, alu_res;
   logic              arith_cout, wr_en, flag_nxt;

   cdalu_arith #(.DATA_W(DATA_W)) u_arith (
      .a(src_a), .b(src_b), .op(op_sel), .cin(flag_in),
      .res(arith_res), .cout(arith_cout)
   );

   cdalu_logic #(.HALF_W(HALF_W)) u_logic (
      .a_hi(src_a[DATA_W-1:HALF_W]), .b_hi(src_b[DATA_W-1:HALF_W]),
      .res(logic_res)
   );

   cdalu_cond u_cond (
      .mode(cond_mode), .flag(flag_in), .op(op_sel), .wr_en(wr_en)
   );

   assign alu_res = (op_sel == OP_AND) ? logic_res : arith_res;

   generate
      if (FLAG_FROM_CARRY) begin : g_flag_carry
         assign flag_nxt = (wr_en && op_sel == OP_ADDC) ? arith_cout : flag_in;
      end else begin : g_flag_pass
         logic unused_cout;
         assign unused_cout = arith_cout;
         assign flag_nxt    = flag_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         dst_q  <= wr_en ? alu_res : dst_cur;
         flag_q <= flag_nxt;
      end
   end

   // R1: reset values
   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_zero: assert (dst_q == '0 && flag_q == 1'b0);
   end

   // R7: mode 3 never writes
   a_r7_never_mode: assert property (@(posedge clk) disable iff (!rst_n)
      cond_mode == CM_NEVER |=> dst_q == $past(dst_cur));

   // R7: flag-gated modes hold when the flag disagrees
   a_r7_flag_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((cond_mode == CM_IFSET && !flag_in) || (cond_mode == CM_IFCLR && flag_in))
      |=> dst_q == $past(dst_cur));

   // R8: unknown codes hold the destination
   a_r8_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
      op_sel > 3'd4 |=> dst_q == $past(dst_cur));

   // R4: AND always leaves the low half at zero when written
   a_r4_and_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_AND && cond_mode == CM_ALWAYS) |=> dst_q[HALF_W-1:0] == '0);

   // R5: increment steps the upper half by one
   a_r5_inc_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_INC && cond_mode == CM_ALWAYS)
      |=> dst_q[DATA_W-1:HALF_W] == HALF_W'($past(src_a[DATA_W-1:HALF_W]) + HALF_W'(1)));

   // R9: flag passes through on non-carry operations
   a_r9_flag_pass: assert property (@(posedge clk) disable iff (!rst_n)
      op_sel != OP_ADDC |=> flag_q == $past(flag_in));

endmodule

// File: tb/test_cdalu_top.sv
`timescale 1ns/1ps
module test_cdalu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_a = '0, src_b = '0, dst_cur = '0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  cond_mode = '0;
   logic        flag_in = 1'b0;
   logic [31:0] dst_q;
   logic        flag_q;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cdalu_top i_cdalu_top (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
      .op_sel(op_sel), .cond_mode(cond_mode), .flag_in(flag_in),
      .dst_cur(dst_cur), .dst_q(dst_q), .flag_q(flag_q)
   );

   function automatic bit writes(input logic [2:0] op, input logic [1:0] m, input logic f);
      bit c;
      c = (m == 2'd0) || (m == 2'd1 && f) || (m == 2'd2 && !f);
      return c && (op <= 3'd4);
   endfunction

   function automatic logic [31:0] model_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] op, input logic f);
      logic [15:0] h;
      case (op)
         3'd0: return a + b;
         3'd1: return a + b + {31'd0, f};
         3'd2: return {a[31:16] & b[31:16], 16'h0};
         3'd3: begin h = a[31:16] + 16'd1; return {h, 16'h0}; end
         3'd4: begin h = a[31:16] - 16'd1; return {h, 16'h0}; end
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag(input logic [2:0] op, input bit w);
      if (!w) return (op > 3'd4) ? "R8" : "R7";
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R10: drive at negedge, sample one edge later
   task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                          input logic [1:0] m, input logic f, input logic [31:0] cur);
      bit w;
      logic [32:0] wide;
      logic exp_f;
      @(negedge clk);
      src_a = a; src_b = b; op_sel = op; cond_mode = m; flag_in = f; dst_cur = cur;
      w = writes(op, m, f);
      wide = {1'b0, a} + {1'b0, b} + {32'd0, f};
      exp_f = (w && op == 3'd1) ? wide[32] : f;
      @(posedge clk); #1;
      check32(tag(op, w), dst_q, w ? model_res(a, b, op, f) : cur);
      check32((w && op == 3'd1) ? "R3" : "R9", {31'd0, flag_q}, {31'd0, exp_f});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] pa [6];
      logic [31:0] pb [6];
      pa[0] = 32'hA5A5A5A5; pb[0] = 32'hA5A5A5A5;
      pa[1] = 32'h5A5A5A5A; pb[1] = 32'hA5A5A5A5;
      pa[2] = 32'h00020000; pb[2] = 32'h00000002;
      pa[3] = 32'hFFFFFFFF; pb[3] = 32'h00000000;
      pa[4] = 32'h0000FFFF; pb[4] = 32'h0000FFFF;
      pa[5] = 32'hFFFF1234; pb[5] = 32'h80008000;

      src_a = 32'hDEADBEEF; dst_cur = 32'h12345678; flag_in = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check32("R1", dst_q, 32'h0);                  // R1
      check32("R1", {31'd0, flag_q}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // directed values
      run_one(32'hA5A5A5A5, 32'hA5A5A5A5, 3'd0, 2'd0, 1'b0, 32'h0);        // R2 -> 4B4B4B4A
      check32("R2", dst_q, 32'h4B4B4B4A);
      run_one(32'd2, 32'd2, 3'd1, 2'd0, 1'b1, 32'h0);                      // R3 -> 5
      check32("R3", dst_q, 32'd5);
      run_one(32'hFFFFFFFF, 32'h0, 3'd1, 2'd0, 1'b1, 32'h7);               // R3 wrap, carry out
      check32("R3", {31'd0, flag_q}, 32'd1);
      run_one(32'h0000ABCD, 32'h0, 3'd4, 2'd0, 1'b0, 32'h0);               // R6 0000 -> FFFF
      check32("R6", dst_q, 32'hFFFF0000);
      run_one(32'hFFFF0001, 32'h0, 3'd3, 2'd0, 1'b0, 32'h0);               // R5 FFFF -> 0000
      check32("R5", dst_q, 32'h00000000);

      // sweep all ops, modes, flags over patterns
      for (int p = 0; p < 6; p++)
         for (int op = 0; op < 8; op++)
            for (int m = 0; m < 4; m++)
               for (int f = 0; f < 2; f++)
                  run_one(pa[p], pb[p], 3'(op), 2'(m), 1'(f), pa[p] ^ 32'h3C3C_0F0F ^ 32'(op));

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule